// File: doc/BRIEF.md
# Multi-Mode Serial Receive Status Unit

This block receives serial characters in one of three operating modes and keeps the flag word that software polls or takes an interrupt on. In the two asynchronous modes it frames characters with a start bit and a stop bit, taking one sample per bit whenever the baud generator pulses `sample_en`. In the clock-synchronous mode it shifts one bit on each rising edge of an external shift clock and has no framing bits at all.

Each finished character is loaded into a data register and flagged ready. The flag word also reports parity, overrun and framing errors. Which errors can be raised, and at what point in the character the ready flag rises, both depend on the mode. Whenever an error flag is raised, the ready flag rises in the same update. While any error flag is 1, the data register must be treated as invalid. A single interrupt request line combines all four flags under an enable bit.

Top module: `serial_rx_status`

## Requirements
- R1: After a synchronous reset, `status`, `rx_data` and `rx_irq` are all zero.
- R2: In the asynchronous modes (`mode`=0 normal, `mode`=1 multiprocessor), the line is sampled on each cycle in which `sample_en`=1. A frame is a 0 start bit, then 8 data bits sent least significant bit first, then one extra bit, then the stop bit. The extra bit is the parity bit in mode 0 when `par_en`=1, is always the address/data bit in mode 1, and is absent in mode 0 when `par_en`=0. Data loads and the ready flag sets only once the stop bit has been sampled, never earlier.
- R3: In clock-synchronous mode (`mode`=2, or 3 which behaves the same), `rxd` is sampled on each rising edge of `sclk_in` after a two-stage synchronizer, and `sample_en` is ignored. Data loads and the ready flag sets after the 8th bit (the last data bit). There is no start bit and no stop bit.
- R4: `status` bit 15 is the parity error flag, bit 14 is overrun, bit 13 is the framing error and bit 12 is data ready. Bits 11..0 read 0. Any error flag that sets also sets data ready in the same update.
- R5: The parity error flag sets only in mode 0 with `par_en`=1, when the data bits and the parity bit together hold an odd number of ones (even parity). It never sets in modes 1, 2 or 3.
- R6: The framing error flag sets when the sampled stop bit is 0, in modes 0 and 1 only. It never sets in the synchronous mode.
- R7: When a frame completes while data ready is already 1, the overrun flag sets, the new character is dropped and `rx_data` keeps the older character.
- R8: A one-cycle pulse on `rd_data` clears data ready and leaves the error flags unchanged.
- R9: A one-cycle pulse on `clr_err` clears all three error flags and leaves data ready unchanged.
- R10: `rx_irq` is a register that follows (any of the four flags) AND `rx_ie`, with a lag of one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 async normal, 1 async multiprocessor, 2/3 clock synchronous |
| par_en | input | 1 | Even parity enable (mode 0) |
| sample_en | input | 1 | Bit sample strobe from the baud generator (async modes) |
| rxd | input | 1 | Serial data line, idles high |
| sclk_in | input | 1 | External shift clock (synchronous mode) |
| rd_data | input | 1 | Read strobe of the data register, clears data ready |
| clr_err | input | 1 | Clear-error strobe |
| rx_ie | input | 1 | Receive interrupt enable |
| status | output | 16 | Flag word: PE bit 15, ORE bit 14, FRE bit 13, ready bit 12 |
| rx_data | output | 8 | Received character |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A frame counter or state machine that falls out of step shows at the ports in one of two ways. Either the ready flag rises at the wrong bit, or a correct character is later loaded shifted by one position. Both appear within two cycles of the sample that finishes the frame. If the per-mode gating of the error flags is wrong, a flag appears in a mode that must never raise it, so the bench sends bad parity and a 0 stop bit in every mode. A wrong overrun path either overwrites `rx_data` or fails to raise bit 14 on the very next completed frame.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int STATUS_W = 16;
  localparam int PE_BIT   = 15;
  localparam int ORE_BIT  = 14;
  localparam int FRE_BIT  = 13;
  localparam int RDY_BIT  = 12;

  typedef enum logic [2:0] {
    SH_IDLE, SH_DATA, SH_EXTRA, SH_STOP
  } shift_state_t;

  function automatic logic mode_is_sync(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/rx_edge_sync.sv
module rx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              par_en,
  input  logic              sample_en,
  input  logic              sclk_rise,
  input  logic              rxd,
  output logic              done,
  output logic [DATA_W-1:0] done_data,
  output logic              par_bad,
  output logic              stop_bad
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  shift_state_t      st;
  logic [DATA_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              extra_bit;
  logic              sync_m;
  logic              tick;
  logic [DATA_W-1:0] sh_next;

  assign sync_m  = mode_is_sync(mode);
  assign tick    = sync_m ? sclk_rise : sample_en;
  assign sh_next = {rxd, sh[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SH_IDLE;
      sh        <= '0;
      cnt       <= '0;
      extra_bit <= 1'b0;
      done      <= 1'b0;
      done_data <= '0;
      par_bad   <= 1'b0;
      stop_bad  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st)
          SH_IDLE: begin
            if (sync_m) begin
              sh  <= sh_next;
              cnt <= CNT_W'(1);
              st  <= SH_DATA;
            end else if (!rxd) begin
              cnt <= '0;
              st  <= SH_DATA;
            end
          end
          SH_DATA: begin
            sh  <= sh_next;
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(DATA_W - 1)) begin
              if (sync_m) begin
                done      <= 1'b1;
                done_data <= sh_next;
                par_bad   <= 1'b0;
                stop_bad  <= 1'b0;
                st        <= SH_IDLE;
              end else if (mode == 2'd1 || par_en) begin
                st <= SH_EXTRA;
              end else begin
                extra_bit <= 1'b0;
                st        <= SH_STOP;
              end
            end
          end
          SH_EXTRA: begin
            extra_bit <= rxd;
            st        <= SH_STOP;
          end
          SH_STOP: begin
            done      <= 1'b1;
            done_data <= sh;
            par_bad   <= (^sh) ^ extra_bit;
            stop_bad  <= ~rxd;
            st        <= SH_IDLE;
          end
          default: st <= SH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_status.sv
module rx_status
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          mode,
  input  logic                par_en,
  input  logic                done,
  input  logic [DATA_W-1:0]   done_data,
  input  logic                par_bad,
  input  logic                stop_bad,
  input  logic                rd_data,
  input  logic                clr_err,
  input  logic                rx_ie,
  output logic [STATUS_W-1:0] status,
  output logic [DATA_W-1:0]   rx_data,
  output logic                rx_irq
);
  logic pe, ore, fre, rdy;
  logic pe_set, fre_set, ore_set, load;

  assign load    = done & ~rdy;
  assign ore_set = done & rdy;
  assign pe_set  = load & par_bad & (mode == 2'd0) & par_en;
  assign fre_set = load & stop_bad & ~mode_is_sync(mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      pe      <= 1'b0;
      ore     <= 1'b0;
      fre     <= 1'b0;
      rdy     <= 1'b0;
      rx_data <= '0;
      rx_irq  <= 1'b0;
    end else begin
      if (load) begin
        rx_data <= done_data;
        rdy     <= 1'b1;
      end else if (rd_data) begin
        rdy <= 1'b0;
      end
      pe     <= pe_set  | (pe  & ~clr_err);
      fre    <= fre_set | (fre & ~clr_err);
      ore    <= ore_set | (ore & ~clr_err);
      rx_irq <= rx_ie & (pe | ore | fre | rdy);
    end
  end

  always_comb begin
    status          = '0;
    status[PE_BIT]  = pe;
    status[ORE_BIT] = ore;
    status[FRE_BIT] = fre;
    status[RDY_BIT] = rdy;
  end
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
  import serial_rx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          mode,
  input  logic                par_en,
  input  logic                sample_en,
  input  logic                rxd,
  input  logic                sclk_in,
  input  logic                rd_data,
  input  logic                clr_err,
  input  logic                rx_ie,
  output logic [STATUS_W-1:0] status,
  output logic [DATA_W-1:0]   rx_data,
  output logic                rx_irq
);
  logic              sclk_rise;
  logic              done, par_bad, stop_bad;
  logic [DATA_W-1:0] done_data;

  rx_edge_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst(rst), .din(sclk_in), .rise(sclk_rise)
  );

  rx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .mode(mode), .par_en(par_en),
    .sample_en(sample_en), .sclk_rise(sclk_rise), .rxd(rxd),
    .done(done), .done_data(done_data), .par_bad(par_bad),
    .stop_bad(stop_bad)
  );

  rx_status #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst(rst), .mode(mode), .par_en(par_en),
    .done(done), .done_data(done_data), .par_bad(par_bad),
    .stop_bad(stop_bad), .rd_data(rd_data), .clr_err(clr_err),
    .rx_ie(rx_ie), .status(status), .rx_data(rx_data), .rx_irq(rx_irq)
  );
endmodule

// File: rtl/serial_rx_status_chk.sv
module serial_rx_status_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode,
  input logic              par_en,
  input logic              rx_ie,
  input logic [15:0]       status,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_irq
);
  // R5
  pe_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status[15]) |-> ($past(mode) == 2'd0 && $past(par_en)));

  // R6
  fre_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status[13]) |-> !$past(mode[1]));

  // R4
  err_sets_ready_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(status[15]) || $rose(status[14]) || $rose(status[13])) |-> status[12]);

  // R7
  ore_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status[14]) |-> $past(status[12]));

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (status[12] && $past(status[12])) |-> $stable(rx_data));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rx_ie) |-> !rx_irq);
endmodule

bind serial_rx_status serial_rx_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .par_en(par_en), .rx_ie(rx_ie),
  .status(status), .rx_data(rx_data), .rx_irq(rx_irq)
);

// File: tb/serial_rx_status_bench.sv
module serial_rx_status_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'd0;
  logic        par_en = 1'b0, sample_en = 1'b0, rxd = 1'b1, sclk_in = 1'b0;
  logic        rd_data = 1'b0, clr_err = 1'b0, rx_ie = 1'b0;
  logic [15:0] status;
  logic [7:0]  rx_data;
  logic        rx_irq;
  int          total = 0, bad = 0;

  always #2.5 clk = ~clk;

  serial_rx_status u_serial_rx_status (
    .clk(clk), .rst(rst), .mode(mode), .par_en(par_en), .sample_en(sample_en),
    .rxd(rxd), .sclk_in(sclk_in), .rd_data(rd_data), .clr_err(clr_err),
    .rx_ie(rx_ie), .status(status), .rx_data(rx_data), .rx_irq(rx_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_tick(input logic b);
    @(negedge clk); rxd = b; sample_en = 1'b1;
    @(negedge clk); sample_en = 1'b0;
    @(negedge clk);
  endtask

  // start + data + optional extra bit; stop sent separately
  task automatic async_body(input logic [7:0] d, input logic has_x, input logic xb);
    bit_tick(1'b0);
    for (int i = 0; i < 8; i++) bit_tick(d[i]);
    if (has_x) bit_tick(xb);
  endtask

  task automatic async_stop(input logic sb);
    bit_tick(sb);
    @(negedge clk); rxd = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic sync_frame(input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); rxd = d[i]; sclk_in = 1'b1;
      repeat (4) @(negedge clk);
      sclk_in = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd_data = 1'b1; @(negedge clk); rd_data = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_err = 1'b1; @(negedge clk); clr_err = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 status", status, 32'h0);
    check("R1 rx_data", rx_data, 32'h0);
    check("R1 rx_irq", rx_irq, 32'h0);
  endtask

  task automatic t_async_plain();
    mode = 2'd0; par_en = 1'b0; rx_ie = 1'b1;
    async_body(8'hA5, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R2 no ready before stop", status, 32'h0);
    async_stop(1'b1);
    check("R2 ready after stop", status, 32'h1000);
    check("R2 data", rx_data, 32'hA5);
    check("R10 irq on ready", rx_irq, 32'h1);
    pulse_rd();
    check("R8 read clears ready", status, 32'h0);
    @(negedge clk);
    check("R10 irq drops", rx_irq, 32'h0);
  endtask

  task automatic t_parity();
    mode = 2'd0; par_en = 1'b1;
    async_body(8'h3C, 1'b1, 1'b0);
    async_stop(1'b1);
    check("R5 good parity", status, 32'h1000);
    check("R5 data", rx_data, 32'h3C);
    pulse_rd();
    async_body(8'h07, 1'b1, 1'b0);
    async_stop(1'b1);
    check("R5 bad parity sets PE+ready", status, 32'h9000);
    pulse_rd();
    check("R8 read keeps error", status, 32'h8000);
    pulse_clr();
    check("R9 clear errors", status, 32'h0);
  endtask

  task automatic t_framing();
    mode = 2'd0; par_en = 1'b0;
    async_body(8'h5A, 1'b0, 1'b0);
    async_stop(1'b0);
    check("R6 framing error", status, 32'h3000);
    check("R6 data", rx_data, 32'h5A);
    pulse_clr();
    check("R9 ready kept on clear", status, 32'h1000);
    pulse_rd();
  endtask

  task automatic t_overrun();
    mode = 2'd0; par_en = 1'b0;
    async_body(8'h11, 1'b0, 1'b0); async_stop(1'b1);
    async_body(8'h22, 1'b0, 1'b0); async_stop(1'b1);
    check("R7 overrun flag", status, 32'h5000);
    check("R7 old data kept", rx_data, 32'h11);
    pulse_rd(); pulse_clr();
    check("R7 cleaned", status, 32'h0);
  endtask

  task automatic t_multiproc();
    mode = 2'd1; par_en = 1'b1;
    async_body(8'h07, 1'b1, 1'b0);
    async_stop(1'b1);
    check("R5 no PE in mode 1", status, 32'h1000);
    check("R2 mode 1 data", rx_data, 32'h07);
    pulse_rd();
    async_body(8'hC3, 1'b1, 1'b1);
    async_stop(1'b0);
    check("R6 FRE in mode 1", status, 32'h3000);
    pulse_rd(); pulse_clr();
  endtask

  task automatic t_sync();
    mode = 2'd2; par_en = 1'b1; rxd = 1'b0;
    bit_tick(1'b0);
    check("R3 sample_en ignored", status, 32'h0);
    sync_frame(8'h96);
    check("R3 ready after bit 7", status, 32'h1000);
    check("R3 data", rx_data, 32'h96);
    sync_frame(8'h01);
    check("R7 sync overrun, no PE/FRE", status, 32'h5000);
    check("R7 sync data kept", rx_data, 32'h96);
    rx_ie = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 irq gated off", rx_irq, 32'h0);
    pulse_rd(); pulse_clr();
    mode = 2'd0; rxd = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_async_plain();
    t_parity();
    t_framing();
    t_overrun();
    t_multiproc();
    t_sync();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule